// File: doc/BRIEF.md
# Speed-Aware Issue Queue Dispatch Steering

This block sits between dispatch and the storage of an out-of-order issue queue in which each entry's two source slots, and its two read/write ports, may not run at the same speed. It registers one dispatched instruction per cycle into the chosen entry. When an instruction has a single source that must still wait for a forwarded result, the block can exchange the two source fields so that the waiting source occupies the faster slot. It keeps one swap bit per entry so the issue read gets the operands back in program order.

Separately, every port access to an entry is steered, one cycle later, onto either the entry's normal port and bus or an alternate port and bus, according to per-entry port speed masks. When no fast choice exists, the block keeps the default placement and raises a slow flag for the stall logic. Tag matching and selection are handled elsewhere.

Top module: `iq_dispatch_steer`

## Requirements
- R1: While rst_n is low and in the first cycle after it, wr_en, wr_swap, disp_slow, bus_norm_en, bus_alt_en and port_stall are 0, and all swap bits are clear (rd_src1_data equals rd_a_data and rd_src2_data equals rd_b_data for every entry).
- R2: A dispatch with disp_valid high at edge n gives wr_en high after edge n, with wr_entry, wr_opcode and wr_dtag equal to the dispatched values; with disp_valid low, wr_en and disp_slow are 0 after that edge.
- R3: A source is live when its used flag is 1 and its ready flag is 0. Without a swap, source 1 (ready, tag, data) is written to slot A and source 2 to slot B, and wr_swap is 0.
- R4: The swap is made exactly when one source is live and the other is not, the live source's default slot is slow and the other slot is fast; slot speeds are read from bit disp_entry of slot_a_slow and slot_b_slow, 1 meaning slow. A swap writes source 1 to slot B, source 2 to slot A, and wr_swap is 1.
- R5: disp_slow is 1 after a dispatch exactly when no swap was made and at least one live source sits in a slow slot; two live sources or two slow slots never cause a swap.
- R6: The swap bit of each entry is held until that entry is written again; rd_src1_data and rd_src2_data return rd_b_data and rd_a_data when the swap bit of rd_entry is 1, otherwise rd_a_data and rd_b_data.
- R7: An access with acc_valid high at edge n drives the bus selection after edge n; when bit acc_entry of port_slow is 0, bus_norm_en is 1 and bus_alt_en is 0.
- R8: When the normal port of the accessed entry is slow and its alternate port (bit acc_entry of alt_slow) is fast, bus_alt_en is 1 and bus_norm_en is 0.
- R9: When both ports of the accessed entry are slow, the normal bus is used and port_stall is 1; otherwise port_stall is 0.
- R10: bus_norm_en and bus_alt_en are never both 1, and both are 0 after a cycle with acc_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_entry | input | IDX_W | Target entry |
| disp_opcode | input | OPC_W | Opcode |
| disp_dtag | input | TAG_W | Destination tag |
| s1_used | input | 1 | Source 1 present |
| s1_ready | input | 1 | Source 1 value available |
| s1_tag | input | TAG_W | Source 1 tag |
| s1_data | input | DATA_W | Source 1 value |
| s2_used | input | 1 | Source 2 present |
| s2_ready | input | 1 | Source 2 value available |
| s2_tag | input | TAG_W | Source 2 tag |
| s2_data | input | DATA_W | Source 2 value |
| slot_a_slow | input | ENTRIES | Per-entry slow flag of slot A |
| slot_b_slow | input | ENTRIES | Per-entry slow flag of slot B |
| wr_en | output | 1 | Entry write strobe (sets the entry valid bit) |
| wr_entry | output | IDX_W | Entry written |
| wr_opcode | output | OPC_W | Opcode written |
| wr_dtag | output | TAG_W | Destination tag written |
| wr_a_ready | output | 1 | Slot A ready bit |
| wr_a_tag | output | TAG_W | Slot A tag |
| wr_a_data | output | DATA_W | Slot A operand |
| wr_b_ready | output | 1 | Slot B ready bit |
| wr_b_tag | output | TAG_W | Slot B tag |
| wr_b_data | output | DATA_W | Slot B operand |
| wr_swap | output | 1 | Sources exchanged in this write |
| disp_slow | output | 1 | Live source left in a slow slot |
| acc_valid | input | 1 | Port access request |
| acc_entry | input | IDX_W | Entry accessed |
| port_slow | input | ENTRIES | Per-entry slow flag of the normal port |
| alt_slow | input | ENTRIES | Per-entry slow flag of the alternate port |
| bus_norm_en | output | 1 | Drive normal port and bus |
| bus_alt_en | output | 1 | Drive alternate port and bus |
| port_stall | output | 1 | Both ports of the accessed entry slow |
| rd_entry | input | IDX_W | Entry being issued |
| rd_a_data | input | DATA_W | Slot A operand read |
| rd_b_data | input | DATA_W | Slot B operand read |
| rd_src1_data | output | DATA_W | Source 1 in program order |
| rd_src2_data | output | DATA_W | Source 2 in program order |

## Verification
The hardest situation to reach is a swap bit surviving in one entry while other entries are rewritten, then being read back through the issue path after many unrelated dispatches. The stimulus draws random entries, used/ready flags and speed masks every cycle, so single-live dispatches into entries with exactly one slow slot occur often, and it reads a random entry every cycle against a model of all swap bits. Directed cycles then force the two-slow-slot, two-live and both-ports-slow corners.

// File: rtl/iq_dispatch_steer.sv
module iq_dispatch_steer #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int OPC_W   = 7,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  input  logic [IDX_W-1:0]   disp_entry,
  input  logic [OPC_W-1:0]   disp_opcode,
  input  logic [TAG_W-1:0]   disp_dtag,
  input  logic               s1_used,
  input  logic               s1_ready,
  input  logic [TAG_W-1:0]   s1_tag,
  input  logic [DATA_W-1:0]  s1_data,
  input  logic               s2_used,
  input  logic               s2_ready,
  input  logic [TAG_W-1:0]   s2_tag,
  input  logic [DATA_W-1:0]  s2_data,
  input  logic [ENTRIES-1:0] slot_a_slow,
  input  logic [ENTRIES-1:0] slot_b_slow,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_entry,
  output logic [OPC_W-1:0]   wr_opcode,
  output logic [TAG_W-1:0]   wr_dtag,
  output logic               wr_a_ready,
  output logic [TAG_W-1:0]   wr_a_tag,
  output logic [DATA_W-1:0]  wr_a_data,
  output logic               wr_b_ready,
  output logic [TAG_W-1:0]   wr_b_tag,
  output logic [DATA_W-1:0]  wr_b_data,
  output logic               wr_swap,
  output logic               disp_slow,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_entry,
  input  logic [ENTRIES-1:0] port_slow,
  input  logic [ENTRIES-1:0] alt_slow,
  output logic               bus_norm_en,
  output logic               bus_alt_en,
  output logic               port_stall,
  input  logic [IDX_W-1:0]   rd_entry,
  input  logic [DATA_W-1:0]  rd_a_data,
  input  logic [DATA_W-1:0]  rd_b_data,
  output logic [DATA_W-1:0]  rd_src1_data,
  output logic [DATA_W-1:0]  rd_src2_data
);

  logic [ENTRIES-1:0] swap_q;
  logic live1, live2, slow_a, slow_b, do_swap, slow_hit;
  logic p_slow, p_alt_slow, use_alt;

  assign live1   = s1_used & ~s1_ready;
  assign live2   = s2_used & ~s2_ready;
  assign slow_a  = slot_a_slow[disp_entry];
  assign slow_b  = slot_b_slow[disp_entry];
  assign do_swap = (live1 ^ live2) &
                   (live1 ? (slow_a & ~slow_b) : (slow_b & ~slow_a));
  assign slow_hit = ~do_swap & ((live1 & slow_a) | (live2 & slow_b));

  assign p_slow     = port_slow[acc_entry];
  assign p_alt_slow = alt_slow[acc_entry];
  assign use_alt    = p_slow & ~p_alt_slow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      wr_entry   <= '0;
      wr_opcode  <= '0;
      wr_dtag    <= '0;
      wr_a_ready <= 1'b0;
      wr_a_tag   <= '0;
      wr_a_data  <= '0;
      wr_b_ready <= 1'b0;
      wr_b_tag   <= '0;
      wr_b_data  <= '0;
      wr_swap    <= 1'b0;
      disp_slow  <= 1'b0;
      swap_q     <= '0;
    end else begin
      wr_en     <= disp_valid;
      disp_slow <= disp_valid & slow_hit;
      if (disp_valid) begin
        wr_entry   <= disp_entry;
        wr_opcode  <= disp_opcode;
        wr_dtag    <= disp_dtag;
        wr_swap    <= do_swap;
        wr_a_ready <= do_swap ? s2_ready : s1_ready;
        wr_a_tag   <= do_swap ? s2_tag   : s1_tag;
        wr_a_data  <= do_swap ? s2_data  : s1_data;
        wr_b_ready <= do_swap ? s1_ready : s2_ready;
        wr_b_tag   <= do_swap ? s1_tag   : s2_tag;
        wr_b_data  <= do_swap ? s1_data  : s2_data;
        swap_q[disp_entry] <= do_swap;
      end else begin
        wr_swap <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_norm_en <= 1'b0;
      bus_alt_en  <= 1'b0;
      port_stall  <= 1'b0;
    end else begin
      bus_norm_en <= acc_valid & ~use_alt;
      bus_alt_en  <= acc_valid & use_alt;
      port_stall  <= acc_valid & p_slow & p_alt_slow;
    end
  end

  assign rd_src1_data = swap_q[rd_entry] ? rd_b_data : rd_a_data;
  assign rd_src2_data = swap_q[rd_entry] ? rd_a_data : rd_b_data;

endmodule

// File: rtl/iq_dispatch_steer_chk.sv
module iq_dispatch_steer_chk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic [IDX_W-1:0]   disp_entry,
  input logic               s1_used,
  input logic               s1_ready,
  input logic [TAG_W-1:0]   s1_tag,
  input logic               s2_used,
  input logic               s2_ready,
  input logic [ENTRIES-1:0] slot_a_slow,
  input logic [ENTRIES-1:0] slot_b_slow,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_entry,
  input logic [TAG_W-1:0]   wr_b_tag,
  input logic               wr_swap,
  input logic               acc_valid,
  input logic [IDX_W-1:0]   acc_entry,
  input logic [ENTRIES-1:0] port_slow,
  input logic [ENTRIES-1:0] alt_slow,
  input logic               bus_norm_en,
  input logic               bus_alt_en,
  input logic               port_stall,
  input logic [IDX_W-1:0]   rd_entry,
  input logic [DATA_W-1:0]  rd_b_data,
  input logic [DATA_W-1:0]  rd_src1_data
);

  a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_norm_en && bus_alt_en));

  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> wr_en && wr_entry == $past(disp_entry));

  a_r4_swap_one_live: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && s1_used && !s1_ready && !(s2_used && !s2_ready) &&
     slot_a_slow[disp_entry] && !slot_b_slow[disp_entry])
    |=> wr_swap && wr_b_tag == $past(s1_tag));

  a_r5_no_swap_two_live: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && s1_used && !s1_ready && s2_used && !s2_ready) |=> !wr_swap);

  a_r6_read_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_swap && rd_entry == wr_entry) |-> rd_src1_data == rd_b_data);

  a_r7_normal_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !port_slow[acc_entry]) |=> bus_norm_en && !port_stall);

  a_r8_alt_route: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && port_slow[acc_entry] && !alt_slow[acc_entry]) |=> bus_alt_en);

  a_r9_both_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && port_slow[acc_entry] && alt_slow[acc_entry])
    |=> bus_norm_en && port_stall);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !bus_norm_en && !bus_alt_en);

endmodule

bind iq_dispatch_steer iq_dispatch_steer_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_entry(disp_entry),
  .s1_used(s1_used), .s1_ready(s1_ready), .s1_tag(s1_tag),
  .s2_used(s2_used), .s2_ready(s2_ready),
  .slot_a_slow(slot_a_slow), .slot_b_slow(slot_b_slow),
  .wr_en(wr_en), .wr_entry(wr_entry), .wr_b_tag(wr_b_tag), .wr_swap(wr_swap),
  .acc_valid(acc_valid), .acc_entry(acc_entry),
  .port_slow(port_slow), .alt_slow(alt_slow),
  .bus_norm_en(bus_norm_en), .bus_alt_en(bus_alt_en), .port_stall(port_stall),
  .rd_entry(rd_entry), .rd_b_data(rd_b_data), .rd_src1_data(rd_src1_data)
);

// File: tb/iq_dispatch_steer_tb_top.sv
`timescale 1ns/1ps
module iq_dispatch_steer_tb_top;
  localparam int ENTRIES = 8;
  localparam int TAG_W   = 6;
  localparam int OPC_W   = 7;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic               disp_valid = 0;
  logic [IDX_W-1:0]   disp_entry = 0;
  logic [OPC_W-1:0]   disp_opcode = 0;
  logic [TAG_W-1:0]   disp_dtag = 0;
  logic               s1_used = 0, s1_ready = 0, s2_used = 0, s2_ready = 0;
  logic [TAG_W-1:0]   s1_tag = 0, s2_tag = 0;
  logic [DATA_W-1:0]  s1_data = 0, s2_data = 0;
  logic [ENTRIES-1:0] slot_a_slow = 0, slot_b_slow = 0, port_slow = 0, alt_slow = 0;
  logic               acc_valid = 0;
  logic [IDX_W-1:0]   acc_entry = 0, rd_entry = 0;
  logic [DATA_W-1:0]  rd_a_data = 0, rd_b_data = 0;
  logic               wr_en, wr_a_ready, wr_b_ready, wr_swap, disp_slow;
  logic [IDX_W-1:0]   wr_entry;
  logic [OPC_W-1:0]   wr_opcode;
  logic [TAG_W-1:0]   wr_dtag, wr_a_tag, wr_b_tag;
  logic [DATA_W-1:0]  wr_a_data, wr_b_data, rd_src1_data, rd_src2_data;
  logic               bus_norm_en, bus_alt_en, port_stall;

  iq_dispatch_steer #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .OPC_W(OPC_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_entry(disp_entry),
    .disp_opcode(disp_opcode), .disp_dtag(disp_dtag),
    .s1_used(s1_used), .s1_ready(s1_ready), .s1_tag(s1_tag), .s1_data(s1_data),
    .s2_used(s2_used), .s2_ready(s2_ready), .s2_tag(s2_tag), .s2_data(s2_data),
    .slot_a_slow(slot_a_slow), .slot_b_slow(slot_b_slow),
    .wr_en(wr_en), .wr_entry(wr_entry), .wr_opcode(wr_opcode), .wr_dtag(wr_dtag),
    .wr_a_ready(wr_a_ready), .wr_a_tag(wr_a_tag), .wr_a_data(wr_a_data),
    .wr_b_ready(wr_b_ready), .wr_b_tag(wr_b_tag), .wr_b_data(wr_b_data),
    .wr_swap(wr_swap), .disp_slow(disp_slow),
    .acc_valid(acc_valid), .acc_entry(acc_entry), .port_slow(port_slow), .alt_slow(alt_slow),
    .bus_norm_en(bus_norm_en), .bus_alt_en(bus_alt_en), .port_stall(port_stall),
    .rd_entry(rd_entry), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .rd_src1_data(rd_src1_data), .rd_src2_data(rd_src2_data));

  int checks = 0, fails = 0;
  bit finished = 0;
  bit swap_m [ENTRIES];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected registered values
  bit e_wr, e_swap, e_slow, e_norm, e_alt, e_stall;
  longint e_a_tag, e_b_tag, e_a_data, e_b_data, e_a_rdy, e_b_rdy, e_ent, e_opc, e_dt;
  string  disp_req, port_req;

  task automatic predict();
    bit l1, l2, sa, sb, ps, as;
    l1 = s1_used && !s1_ready;
    l2 = s2_used && !s2_ready;
    sa = slot_a_slow[disp_entry];
    sb = slot_b_slow[disp_entry];
    e_wr = disp_valid;
    e_swap = 0;
    if (disp_valid) begin
      if (l1 && !l2 && sa && !sb) e_swap = 1;
      if (l2 && !l1 && sb && !sa) e_swap = 1;
    end
    e_slow = disp_valid && !e_swap && ((l1 && sa) || (l2 && sb));
    disp_req = e_swap ? "R4" : (e_slow ? "R5" : "R3");
    e_ent = disp_entry; e_opc = disp_opcode; e_dt = disp_dtag;
    e_a_tag  = e_swap ? s2_tag : s1_tag;     e_b_tag  = e_swap ? s1_tag : s2_tag;
    e_a_data = e_swap ? s2_data : s1_data;   e_b_data = e_swap ? s1_data : s2_data;
    e_a_rdy  = e_swap ? s2_ready : s1_ready; e_b_rdy  = e_swap ? s1_ready : s2_ready;
    ps = port_slow[acc_entry];
    as = alt_slow[acc_entry];
    e_alt = acc_valid && ps && !as;
    e_norm = acc_valid && !e_alt;
    e_stall = acc_valid && ps && as;
    port_req = !acc_valid ? "R10" : (!ps ? "R7" : (as ? "R9" : "R8"));
  endtask

  task automatic check_read(string req);
    chk(req, rd_src1_data, swap_m[rd_entry] ? rd_b_data : rd_a_data);
    chk(req, rd_src2_data, swap_m[rd_entry] ? rd_a_data : rd_b_data);
  endtask

  task automatic cycle(bit directed);
    if (!directed) begin
      disp_valid = ($urandom % 4) != 0;
      disp_entry = IDX_W'($urandom);
      disp_opcode = OPC_W'($urandom);
      disp_dtag = TAG_W'($urandom);
      s1_used = $urandom % 2; s1_ready = $urandom % 2;
      s2_used = $urandom % 2; s2_ready = $urandom % 2;
      s1_tag = TAG_W'($urandom); s2_tag = TAG_W'($urandom);
      s1_data = DATA_W'($urandom); s2_data = DATA_W'($urandom);
      slot_a_slow = ENTRIES'($urandom); slot_b_slow = ENTRIES'($urandom);
      port_slow = ENTRIES'($urandom); alt_slow = ENTRIES'($urandom);
      acc_valid = ($urandom % 4) != 0;
      acc_entry = IDX_W'($urandom);
    end
    rd_entry = IDX_W'($urandom);
    rd_a_data = DATA_W'($urandom);
    rd_b_data = DATA_W'($urandom);
    #1;
    check_read("R6");
    predict();
    @(posedge clk); #1;
    chk("R2", wr_en, e_wr);
    chk(disp_req, wr_swap, e_swap);
    chk("R5", disp_slow, e_slow);
    if (e_wr) begin
      chk("R2", wr_entry, e_ent);
      chk("R2", wr_opcode, e_opc);
      chk("R2", wr_dtag, e_dt);
      chk(disp_req, wr_a_tag, e_a_tag);
      chk(disp_req, wr_b_tag, e_b_tag);
      chk(disp_req, wr_a_data, e_a_data);
      chk(disp_req, wr_b_data, e_b_data);
      chk(disp_req, wr_a_ready, e_a_rdy);
      chk(disp_req, wr_b_ready, e_b_rdy);
      swap_m[e_ent] = e_swap;
    end
    chk(port_req, bus_norm_en, e_norm);
    chk(port_req, bus_alt_en, e_alt);
    chk("R9", port_stall, e_stall);
    chk("R10", bus_norm_en && bus_alt_en, 0);
    @(negedge clk);
  endtask

  task automatic set_disp(int ent, bit u1, bit r1, bit u2, bit r2, bit sa, bit sb);
    disp_valid = 1; disp_entry = IDX_W'(ent);
    s1_used = u1; s1_ready = r1; s2_used = u2; s2_ready = r2;
    s1_tag = 6'h11; s2_tag = 6'h22; s1_data = 16'hAAAA; s2_data = 16'h5555;
    slot_a_slow = '0; slot_b_slow = '0;
    slot_a_slow[ent] = sa; slot_b_slow[ent] = sb;
  endtask

  task automatic set_acc(int ent, bit ps, bit as);
    acc_valid = 1; acc_entry = IDX_W'(ent);
    port_slow = '0; alt_slow = '0;
    port_slow[ent] = ps; alt_slow[ent] = as;
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) swap_m[i] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", wr_en, 0); chk("R1", wr_swap, 0); chk("R1", disp_slow, 0);
    chk("R1", bus_norm_en, 0); chk("R1", bus_alt_en, 0); chk("R1", port_stall, 0);
    for (int i = 0; i < ENTRIES; i++) begin
      rd_entry = IDX_W'(i); rd_a_data = 16'h1234; rd_b_data = 16'hBEEF; #1;
      chk("R1", rd_src1_data, 16'h1234);
      chk("R1", rd_src2_data, 16'hBEEF);
    end
    rst_n = 1;
    @(negedge clk);
    // directed corners
    set_disp(2, 1, 0, 0, 0, 1, 0); set_acc(1, 0, 0); cycle(1);  // R4 swap, R7
    set_disp(3, 0, 0, 1, 0, 0, 1); set_acc(1, 1, 0); cycle(1);  // R4 src2 to A, R8
    set_disp(4, 1, 0, 0, 0, 1, 1); set_acc(5, 1, 1); cycle(1);  // R5 both slots slow, R9
    set_disp(5, 1, 0, 1, 0, 1, 0); set_acc(5, 0, 1); cycle(1);  // R5 two live
    set_disp(6, 1, 1, 0, 0, 1, 0); acc_valid = 0; cycle(1);     // R3 ready source, R10 idle
    disp_valid = 0; cycle(1);                                    // R2 idle
    for (int i = 0; i < ENTRIES; i++) begin                      // R6 stored bits
      disp_valid = 0; acc_valid = 0; cycle(1);
    end
    for (int n = 0; n < 3000; n++) cycle(0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule